// File: doc/BRIEF.md
# Steerable Processor Watchdog with Frequency-Test Arbitration

This block watches a processor for signs of life. Software programs one 8-bit control register: the upper bit chooses where a timeout goes, the next five bits hold a multiplier, and the low two bits pick a time unit. The timeout period is the multiplier times the chosen unit. Any read or write of that register restarts the period. When the period runs out, the block either raises a sticky watchdog flag that drives the shared interrupt pin, or emits a timed reset pulse and disarms itself.

The same interrupt pin can also carry a 512 Hz square wave for frequency testing, and it carries an alarm request from elsewhere. The block decides what the pin shows. A watchdog that is armed and aimed at the interrupt pin always blocks the test wave. Time comes in as two single-cycle strobes: one at 16 Hz for counting and one at 1024 Hz for making the wave. The pad drivers and power-fail sensing live outside the block.

Top module: `wdog_steer`

## Requirements
- R1: After reset the control register reads 0x00, the watchdog flag and the test bit read 0, and both `irq_ft` and `rst_out` are low.
- R2: The register layout is: bit 7 is the steering bit, bits 6:2 are the multiplier M, and bits 1:0 are the unit code U (00 = 1, 01 = 4, 10 = 16, 11 = 64 ticks). With M nonzero, the timeout fires on the M·unit-th `tick16` strobe after the last register access. For example, 0x05 times out after 4 ticks and 0x0E after 48 ticks.
- R3: With M = 0 the watchdog never times out, whatever the value of U.
- R4: A read (`reg_rd`) or write (`reg_wr`) of the control register restarts the full period.
- R5: A timeout with the steering bit at 0 sets `wf_q` and drives `irq_ft` high. Both stay high until `flag_rd` or an access to the control register.
- R6: A timeout with the steering bit at 1 drives `rst_out` high for exactly RST_CYC clock cycles. It clears the control register and the test bit, and it leaves `wf_q` at 0, so the watchdog stops.
- R7: When the test bit is 1, `ae` is 0, and either the steering bit is 1 or the register is 0x00, `irq_ft` follows a square wave that toggles on each `tick1024` strobe. This square wave starts low after reset.
- R8: When the steering bit is 0 and the register is nonzero, the test wave never reaches `irq_ft`.
- R9: When `alarm_irq` is high, `irq_ft` is high.
- R10: A register access in the same cycle as the expiring tick wins: there is no timeout, and the period restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| tick16 | input | 1 | One-cycle strobe at 16 Hz |
| tick1024 | input | 1 | One-cycle strobe at 1024 Hz |
| reg_wr | input | 1 | Write the control register |
| reg_rd | input | 1 | Read access to the control register (restarts the period) |
| wr_data | input | 8 | Write data for the control register |
| wd_q | output | 8 | Control register contents |
| flag_rd | input | 1 | Read of the flag register (clears the watchdog flag) |
| wf_q | output | 1 | Watchdog flag |
| ft_wr | input | 1 | Write the test bit |
| ft_wdata | input | 1 | Test bit write value |
| ft_q | output | 1 | Test bit |
| ae | input | 1 | Alarm interrupt enable (blocks the test wave) |
| alarm_irq | input | 1 | Alarm interrupt request |
| irq_ft | output | 1 | Shared interrupt/test pin, active high |
| rst_out | output | 1 | Reset pulse, active high |

## Verification
A period counter loaded with a wrong value shows up as a flag or reset pulse on the wrong `tick16` strobe. The bench therefore counts strobes one at a time around each expected expiry, so an off-by-one error is visible within one tick. A stuck or mis-steered flag appears on `irq_ft` in the cycle after the timeout, or persists past a clearing access. A reset counter of the wrong length changes the high time of `rst_out` by whole cycles, and the bench measures that high time exactly. A wrong arbitration state appears on `irq_ft` at the next `tick1024` toggle.

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int MULT_W  = 5,
  parameter int RST_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              tick1024,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [MULT_W+2:0] wr_data,
  output logic [MULT_W+2:0] wd_q,
  input  logic              flag_rd,
  output logic              wf_q,
  input  logic              ft_wr,
  input  logic              ft_wdata,
  output logic              ft_q,
  input  logic              ae,
  input  logic              alarm_irq,
  output logic              irq_ft,
  output logic              rst_out
);
  localparam int RW = MULT_W + 3;
  localparam int CW = MULT_W + 6;
  localparam int PW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic [RW-1:0] src;
  logic [CW-1:0] pre;
  logic          acc, en, tmo, steer, sq, ft_on;

  assign acc   = reg_wr | reg_rd;
  assign src   = reg_wr ? wr_data : wd_q;
  assign pre   = CW'(src[RW-2:2]) << {src[1:0], 1'b0};
  assign steer = wd_q[RW-1];
  assign en    = |wd_q[RW-2:2];
  assign tmo   = tick16 & en & (cnt == CW'(1)) & ~acc;
  assign ft_on = ft_q & ~ae & (steer | (wd_q == '0)) & sq;

  assign irq_ft  = wf_q | alarm_irq | ft_on;
  assign rst_out = (pcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      wd_q <= '0;
      wf_q <= 1'b0;
      ft_q <= 1'b0;
      pcnt <= '0;
      sq   <= 1'b0;
    end else begin
      if (acc || tmo)          cnt <= pre;
      else if (tick16 && en)   cnt <= cnt - CW'(1);

      if (reg_wr)              wd_q <= wr_data;
      else if (tmo && steer)   wd_q <= '0;

      if (tmo && !steer)       wf_q <= 1'b1;
      else if (flag_rd || acc) wf_q <= 1'b0;

      if (tmo && steer)        ft_q <= 1'b0;
      else if (ft_wr)          ft_q <= ft_wdata;

      if (tmo && steer)        pcnt <= PW'(RST_CYC);
      else if (pcnt != '0)     pcnt <= pcnt - PW'(1);

      if (tick1024)            sq <= ~sq;
    end
  end

  a_r5_wf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_q && !flag_rd && !reg_wr && !reg_rd) |=> wf_q);
  a_r4_access_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> (!$rose(wf_q) && !$rose(rst_out)));
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q[RW-2:2] == '0 && !reg_wr) |=> (!$rose(wf_q) && !$rose(rst_out)));
  a_r6_clears_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> (wd_q == '0 && !ft_q));
  a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PW'(RST_CYC));
  a_r8_ft_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (!steer && wd_q != '0 && !wf_q && !alarm_irq) |-> !irq_ft);
endmodule

// File: tb/sim_wdog_steer.sv
module sim_wdog_steer;
  localparam int RC = 10;
  logic clk = 0, rst_n = 0;
  logic tick16 = 0, tick1024 = 0, reg_wr = 0, reg_rd = 0, flag_rd = 0;
  logic ft_wr = 0, ft_wdata = 0, ae = 0, alarm_irq = 0;
  logic [7:0] wr_data = 0, wd_q;
  logic wf_q, ft_q, irq_ft, rst_out;
  int nrun = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_steer #(.MULT_W(5), .RST_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tick1024(tick1024),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data), .wd_q(wd_q),
    .flag_rd(flag_rd), .wf_q(wf_q), .ft_wr(ft_wr), .ft_wdata(ft_wdata),
    .ft_q(ft_q), .ae(ae), .alarm_irq(alarm_irq), .irq_ft(irq_ft), .rst_out(rst_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick16 = 1; @(negedge clk); tick16 = 0;
    end
  endtask
  task automatic tf();
    tick1024 = 1; @(negedge clk); tick1024 = 0;
  endtask
  task automatic wr(input logic [7:0] d);
    reg_wr = 1; wr_data = d; @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd();
    reg_rd = 1; @(negedge clk); reg_rd = 0;
  endtask
  task automatic frd();
    flag_rd = 1; @(negedge clk); flag_rd = 0;
  endtask
  task automatic setft(input logic v);
    ft_wr = 1; ft_wdata = v; @(negedge clk); ft_wr = 0;
  endtask

  task automatic t_reset();
    chk(wd_q == 0, "R1 reg", wd_q, 0);
    chk(!wf_q && !ft_q, "R1 flags", {wf_q, ft_q}, 0);
    chk(!irq_ft && !rst_out, "R1 pins", {irq_ft, rst_out}, 0);
  endtask

  task automatic t_period();
    wr(8'h05); tk(3);
    chk(!wf_q, "R2 0x05 early", wf_q, 0);
    tk(1);
    chk(wf_q && irq_ft, "R2 0x05 fire", {wf_q, irq_ft}, 3);
    frd();
    chk(!wf_q && !irq_ft, "R5 flag_rd clears", {wf_q, irq_ft}, 0);
    wr(8'h0E); tk(47);
    chk(!wf_q, "R2 0x0E early", wf_q, 0);
    tk(1);
    chk(wf_q, "R2 0x0E fire at 48", wf_q, 1);
  endtask

  task automatic t_hold();
    idle(6);
    chk(wf_q && irq_ft, "R5 hold", {wf_q, irq_ft}, 3);
    rd();
    chk(!wf_q && !irq_ft, "R5 access clears", {wf_q, irq_ft}, 0);
  endtask

  task automatic t_restart();
    wr(8'h05); tk(3); rd(); tk(3);
    chk(!wf_q, "R4 read restarts", wf_q, 0);
    tk(1);
    chk(wf_q, "R4 fire after restart", wf_q, 1);
    frd();
    wr(8'h05); tk(3);
    tick16 = 1; reg_wr = 1; wr_data = 8'h05; @(negedge clk);
    tick16 = 0; reg_wr = 0;
    chk(!wf_q, "R10 access wins", wf_q, 0);
    tk(3);
    chk(!wf_q, "R10 restarted early", wf_q, 0);
    tk(1);
    chk(wf_q, "R10 restarted fire", wf_q, 1);
    frd();
  endtask

  task automatic t_disabled();
    wr(8'h03); tk(200);
    chk(!wf_q && !rst_out, "R3 mult zero", {wf_q, rst_out}, 0);
  endtask

  task automatic t_reset_pulse();
    int hi = 0;
    setft(1);
    wr(8'h85); tk(3);
    chk(!rst_out, "R6 early", rst_out, 0);
    tk(1);
    chk(wd_q == 0 && !ft_q, "R6 clears reg/ft", {wd_q, ft_q}, 0);
    chk(!wf_q, "R6 no flag", wf_q, 0);
    while (rst_out && hi < 100) begin hi++; @(negedge clk); end
    chk(hi == RC, "R6 pulse width", hi, RC);
    tk(10);
    chk(!rst_out && !wf_q, "R6 stopped", {rst_out, wf_q}, 0);
  endtask

  task automatic t_ftest();
    wr(8'h00); setft(1);
    chk(!irq_ft, "R7 wave low", irq_ft, 0);
    tf();
    chk(irq_ft, "R7 wave high", irq_ft, 1);
    tf();
    chk(!irq_ft, "R7 wave low again", irq_ft, 0);
    ae = 1; tf();
    chk(!irq_ft, "R7 ae blocks", irq_ft, 0);
    ae = 0; tf();
    chk(!irq_ft, "R7 wave low after ae", irq_ft, 0);
    wr(8'hFF); tf();
    chk(irq_ft, "R7 steer=1 allows", irq_ft, 1);
    tf();
  endtask

  task automatic t_override();
    int seen = 0;
    wr(8'h7D);
    for (int i = 0; i < 4; i++) begin
      tf(); seen += irq_ft;
    end
    chk(seen == 0, "R8 wave denied", seen, 0);
  endtask

  task automatic t_alarm();
    alarm_irq = 1; @(negedge clk);
    chk(irq_ft, "R9 alarm passes", irq_ft, 1);
    alarm_irq = 0; @(negedge clk);
    chk(!irq_ft, "R9 alarm drops", irq_ft, 0);
  endtask

  initial begin
    idle(3); rst_n = 1; @(negedge clk);
    t_reset();
    t_period();
    t_hold();
    t_restart();
    t_disabled();
    t_reset_pulse();
    t_ftest();
    t_override();
    t_alarm();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nrun++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule